// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block is a watchdog that software keeps alive. A 16-bit up-counter advances on a prescaled tick from the core clock. When the counter reaches the terminal value 0x7CFF, the block raises a status flag and a reset request toward the system reset generator. Software pushes the counter back by a two-step refresh. First it writes the arming strobe. Then, within a short window, it writes the start strobe. The counter is then reloaded from an 8-bit reload register. Bit 7 of that register picks the slow tick rate. Bits 6..0 form the high byte of the reloaded count, and the low byte becomes zero.

The block comes out of reset stopped. A start strobe switches it on, and after that only a reset switches it off. The run control is a two-state machine: `RUN_OFF` goes to `RUN_ON` on a start strobe, and `RUN_ON` stays in `RUN_ON` until reset. The arming window is a second two-state machine. `WIN_SHUT` goes to `WIN_OPEN` on an arming strobe. `WIN_OPEN` reloads its 12-clock budget on a further arming strobe. It returns to `WIN_SHUT` when a refresh consumes it or when the budget runs out.

Top module: `twostep_wdt`

## Requirements
- R1: While running, the counter advances by one every 24 clocks when reload bit 7 is 0, and every 384 clocks when reload bit 7 is 1. It wraps from 0xFFFF to 0.
- R2: After reset the block is stopped, the counter is 0, both outputs are low and the reload register reads 0. A start strobe starts the block. Only reset stops it again.
- R3: `timeout_flag` and `reset_req` are high exactly while the block is running and the counter equals 0x7CFF. At the fast rate they stay high for 24 clocks and drop when the counter moves on.
- R4: A start strobe sampled 1 to 12 clocks after an arming strobe is a refresh. It loads the counter with high byte {0, reload[6:0]} and low byte 0, and restarts the prescaler, so the next increment comes one full tick period later. A refresh while stopped also starts the block.
- R5: While running, a start strobe with no live arming (never armed, or armed 13 or more clocks earlier) has no effect on the counter or the outputs.
- R6: The reload register can be written at any clock. `reload_rdata` shows the new value from the next clock on. A refresh in the same clock as a write uses the old value.
- R7: A new arming strobe restarts the 12-clock window. A refresh consumes the arming, so a second start strobe with no new arming does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_wr | input | 1 | Arming flag write strobe |
| start_wr | input | 1 | Start flag write strobe |
| reload_wr | input | 1 | Reload register write strobe |
| reload_wdata | input | 8 | Reload register write data; bit 7 selects the slow rate, bits 6..0 give the high byte |
| reload_rdata | output | 8 | Reload register read data |
| timeout_flag | output | 1 | Status flag, high while the counter sits at the terminal value |
| reset_req | output | 1 | Reset request to the system reset generator |

## Verification
The main function is driven with refreshes at window delays of 12, after a re-arm, and directly followed by a stray start. It is also driven with late starts at delay 13 and with bare starts, and with both reload rates. The clock count from a refresh to the rising reset request tells a correct reload and a prescaler restart apart from an off-by-one window, a missed restart or a wrong rate. Stray and late starts leave that count at its nominal value only if they are truly ignored. A reset in mid-run followed by a long quiet stretch shows that only reset stops the block.

// File: rtl/twostep_wdt_pkg.sv
package twostep_wdt_pkg;
    typedef enum logic {RUN_OFF = 1'b0, RUN_ON = 1'b1} run_state_t;
    typedef enum logic {WIN_SHUT = 1'b0, WIN_OPEN = 1'b1} win_state_t;
endpackage

// File: rtl/twostep_wdt_presc.sv
module twostep_wdt_presc #(
    parameter int DIV_FAST = 24,
    parameter int DIV_SLOW = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic slow,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    assign limit = slow ? LIM_SLOW : LIM_FAST;
    // >= keeps a rate change mid-period from overshooting the shorter limit
    assign tick  = run && !restart && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart || !run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/twostep_wdt_window.sv
module twostep_wdt_window
    import twostep_wdt_pkg::*;
#(
    parameter int WIN = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arm_wr,
    input  logic                       consume,
    output logic                       armed,
    output logic [$clog2(WIN+1)-1:0]   left
);
    localparam int LW = $clog2(WIN + 1);

    win_state_t      st_q, st_nxt;
    logic [LW-1:0]   left_q, left_nxt;

    always_comb begin
        st_nxt   = st_q;
        left_nxt = left_q;
        unique case (st_q)
            WIN_SHUT: begin
                if (arm_wr) begin
                    st_nxt   = WIN_OPEN;
                    left_nxt = LW'(WIN);
                end
            end
            WIN_OPEN: begin
                if (arm_wr) begin
                    left_nxt = LW'(WIN);
                end else if (consume || left_q == LW'(1)) begin
                    st_nxt   = WIN_SHUT;
                    left_nxt = '0;
                end else begin
                    left_nxt = left_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WIN_SHUT;
            left_q <= '0;
        end else begin
            st_q   <= st_nxt;
            left_q <= left_nxt;
        end
    end

    assign armed = (st_q == WIN_OPEN);
    assign left  = left_q;
endmodule

// File: rtl/twostep_wdt.sv
module twostep_wdt
    import twostep_wdt_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          RLD_W    = 8,
    parameter int          DIV_FAST = 24,
    parameter int          DIV_SLOW = 384,
    parameter int          WIN      = 12,
    parameter logic [15:0] TERM     = 16'h7CFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_wr,
    input  logic             start_wr,
    input  logic             reload_wr,
    input  logic [RLD_W-1:0] reload_wdata,
    output logic [RLD_W-1:0] reload_rdata,
    output logic             timeout_flag,
    output logic             reset_req
);
    localparam int LOW_W = CNT_W - RLD_W;
    localparam int LW    = $clog2(WIN + 1);

    run_state_t        run_q, run_nxt;
    logic [CNT_W-1:0]  count_q;
    logic [RLD_W-1:0]  reload_q;
    logic              armed;
    logic              refresh;
    logic              restart;
    logic              tick;
    logic              running;
    logic [LW-1:0]     win_left;

    assign running = (run_q == RUN_ON);
    assign refresh = start_wr && armed;
    assign restart = refresh || (start_wr && !running);

    twostep_wdt_window #(.WIN(WIN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_wr  (arm_wr),
        .consume (refresh),
        .armed   (armed),
        .left    (win_left)
    );

    twostep_wdt_presc #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (restart),
        .slow    (reload_q[RLD_W-1]),
        .tick    (tick)
    );

    // run control: next state
    always_comb begin
        run_nxt = run_q;
        unique case (run_q)
            RUN_OFF: if (start_wr) run_nxt = RUN_ON;
            RUN_ON:  run_nxt = RUN_ON;
        endcase
    end

    // run control: state register
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= RUN_OFF;
        else        run_q <= run_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (refresh) begin
            count_q <= {1'b0, reload_q[RLD_W-2:0], {LOW_W{1'b0}}};
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_wr) reload_q <= reload_wdata;
    end

    // outputs
    always_comb begin
        reload_rdata = reload_q;
        timeout_flag = 1'b0;
        reset_req    = 1'b0;
        unique case (run_q)
            RUN_OFF: ;
            RUN_ON: begin
                timeout_flag = (count_q == TERM[CNT_W-1:0]);
                reset_req    = (count_q == TERM[CNT_W-1:0]);
            end
        endcase
    end
endmodule

// File: rtl/twostep_wdt_chk.sv
module twostep_wdt_chk #(
    parameter int CNT_W = 16,
    parameter int RLD_W = 8,
    parameter int WIN   = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_wr,
    input logic                     armed,
    input logic                     running,
    input logic [CNT_W-1:0]         count,
    input logic                     reset_req,
    input logic                     reload_wr,
    input logic [RLD_W-1:0]         reload_wdata,
    input logic [RLD_W-1:0]         reload_rdata,
    input logic [$clog2(WIN+1)-1:0] win_left
);
    localparam int LOW_W = CNT_W - RLD_W;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(start_wr && armed)) |=>
        (count == $past(count) || count == $past(count) + 1'b1)); // R1

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (count == '0 && !reset_req)); // R2

    AST_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (!reset_req || $stable(count))); // R3

    AST_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && armed) |=> (count[LOW_W-1:0] == '0 && !count[CNT_W-1])); // R4

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (win_left <= ($clog2(WIN+1))'(WIN)) && (armed == (win_left != '0))); // R5

    AST_RELOAD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (reload_rdata == $past(reload_wdata))); // R6
endmodule

bind twostep_wdt twostep_wdt_chk #(.CNT_W(CNT_W), .RLD_W(RLD_W), .WIN(WIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_wr     (start_wr),
    .armed        (armed),
    .running      (running),
    .count        (count_q),
    .reset_req    (reset_req),
    .reload_wr    (reload_wr),
    .reload_wdata (reload_wdata),
    .reload_rdata (reload_rdata),
    .win_left     (win_left)
);

// File: tb/twostep_wdt_bench.sv
module twostep_wdt_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm_wr = 1'b0;
    logic       start_wr = 1'b0;
    logic       reload_wr = 1'b0;
    logic [7:0] reload_wdata = 8'h00;
    logic [7:0] reload_rdata;
    logic       timeout_flag;
    logic       reset_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit         m_run = 1'b0;
    int         m_cnt = 0;
    int         m_pre = 0;
    int         m_win = 0;
    logic [7:0] m_rld = 8'h00;

    twostep_wdt u_twostep_wdt (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_wr       (arm_wr),
        .start_wr     (start_wr),
        .reload_wr    (reload_wr),
        .reload_wdata (reload_wdata),
        .reload_rdata (reload_rdata),
        .timeout_flag (timeout_flag),
        .reset_req    (reset_req)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_run = 1'b0; m_cnt = 0; m_pre = 0; m_win = 0; m_rld = 8'h00;
        end else begin
            int  div;
            bit  live;
            logic [7:0] old_rld;
            old_rld = m_rld;
            div  = old_rld[7] ? 384 : 24;
            live = (m_win > 0);
            if (start_wr && (live || !m_run)) begin
                m_run = 1'b1;
                m_pre = 0;
                if (live) m_cnt = int'(old_rld[6:0]) * 256;
            end else if (m_run) begin
                if (m_pre >= div - 1) begin
                    m_pre = 0;
                    m_cnt = (m_cnt + 1) % 65536;
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (arm_wr)                 m_win = 12;
            else if (start_wr && live)  m_win = 0;
            else if (m_win > 0)         m_win = m_win - 1;
            if (reload_wr) m_rld = reload_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_req;
            exp_req = m_run && (m_cnt == 32'h7CFF);
            chk(reset_req == exp_req, "R3 model reset_req", int'(reset_req), int'(exp_req));
            chk(timeout_flag == exp_req, "R3 model timeout_flag", int'(timeout_flag), int'(exp_req));
            chk(reload_rdata == m_rld, "R6 model reload_rdata", int'(reload_rdata), int'(m_rld));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reload(input logic [7:0] v);
        @(negedge clk); reload_wr = 1'b1; reload_wdata = v;
        @(negedge clk); reload_wr = 1'b0;
    endtask

    // arm, then start 'delay' clocks later; returns at the negedge after the start edge
    task automatic arm_then_start(input int delay);
        @(negedge clk); arm_wr = 1'b1;
        @(negedge clk); arm_wr = 1'b0;
        idle(delay - 1);
        start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic pulse_start;
        start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic wait_req(input int limit, output int elapsed, input int t0);
        int n = 0;
        while (!reset_req && n < limit) begin
            @(negedge clk); n++;
        end
        elapsed = cyc - t0;
    endtask

    initial begin
        int t0, el, hi;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        chk(!reset_req && !timeout_flag, "R2 reset outputs low", int'(reset_req), 0);
        chk(reload_rdata == 8'h00, "R2 reload reads zero after reset", int'(reload_rdata), 0);
        idle(200);
        chk(!reset_req, "R2 stopped stays quiet", int'(reset_req), 0);

        write_reload(8'h7C);
        chk(reload_rdata == 8'h7C, "R6 reload readback", int'(reload_rdata), 8'h7C);

        // first start through a refresh while stopped
        arm_then_start(12);
        t0 = cyc;
        wait_req(10000, el, t0);
        chk(el == 255 * 24, "R1 R4 fast timeout delay", el, 255 * 24);
        hi = 0;
        while (reset_req && hi < 1000) begin @(negedge clk); hi++; end
        chk(hi == 24, "R3 request width", hi, 24);

        // valid refresh at delay 12, then late and bare starts
        arm_then_start(12);
        t0 = cyc;
        idle(50);
        arm_then_start(13);
        idle(30);
        pulse_start();
        wait_req(10000, el, t0);
        chk(el == 255 * 24, "R5 ignored late and bare starts", el, 255 * 24);

        // re-arm restarts window; refresh consumes arming
        @(negedge clk); arm_wr = 1'b1;
        @(negedge clk); arm_wr = 1'b0;
        idle(7);
        arm_then_start(10);
        t0 = cyc;
        @(negedge clk);
        pulse_start();
        wait_req(10000, el, t0);
        chk(el == 255 * 24, "R7 rearm and consumed arm", el, 255 * 24);

        // same-clock write and refresh uses old value, then slow rate
        @(negedge clk); arm_wr = 1'b1;
        @(negedge clk); arm_wr = 1'b0;
        idle(4);
        start_wr = 1'b1; reload_wr = 1'b1; reload_wdata = 8'hFC;
        @(negedge clk); start_wr = 1'b0; reload_wr = 1'b0;
        t0 = cyc;
        chk(reload_rdata == 8'hFC, "R6 write visible next clock", int'(reload_rdata), 8'hFC);
        idle(300);
        chk(!reset_req, "R6 refresh used old reload", int'(reset_req), 0);
        arm_then_start(5);
        t0 = cyc;
        wait_req(120000, el, t0);
        chk(el == 255 * 384, "R1 slow timeout delay", el, 255 * 384);

        // reset stops it
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        chk(!reset_req && reload_rdata == 8'h00, "R2 reset mid-run", int'(reload_rdata), 0);
        hi = 0;
        for (int i = 0; i < 7000; i++) begin
            @(negedge clk);
            if (reset_req) hi++;
        end
        chk(hi == 0, "R2 stays stopped after reset", hi, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(190000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule